// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a 1024-row EDO DRAM alive and brings it up after reset. An interval timer records that a refresh is owed once every refresh period. The owed refreshes are held in a small saturating counter. The block asks the access controller for the memory pins with a request/grant handshake. Once granted, it drives the row strobe and both byte-lane column strobes itself and runs one CAS-before-RAS refresh. That kind of refresh needs no row address, because the device steps its own internal row counter. The write strobe is held high throughout.

After reset the sequencer keeps all strobes inactive for a programmable pause. It then runs eight back-to-back CAS-before-RAS dummy cycles and only after that raises its ready output. The access controller must issue no memory accesses before ready is high. A restart pulse repeats the eight dummy cycles without the pause, for use after the clocks have been stopped for a long time. If refreshes keep being postponed and the owed count reaches eight, an urgent flag is raised. While that flag is high the block starts refreshes without waiting for the grant, until the owed count falls below eight again.

All timing is given in clock cycles through parameters. These cover the pause, the refresh interval, the CAS setup time before RAS, the CAS hold time after RAS, the RAS low width and the precharge time.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is asserted, ras_n_o, cas_hi_n_o, cas_lo_n_o and we_n_o are 1, and mem_ready_o, rfsh_req_o and bus_own_o are 0.
- R2: After reset is released, both CAS lines stay high for the first PAUSE_CYC cycles. RAS first goes low exactly PAUSE_CYC + CAS_SETUP_CYC cycles after release.
- R3: mem_ready_o rises only after exactly eight refresh cycles have been run since reset.
- R4: Every time RAS falls, both CAS lines (0 = active) are already low and have been low for CAS_SETUP_CYC cycles.
- R5: After RAS falls, both CAS lines stay low for exactly CAS_HOLD_CYC cycles. They return high before RAS rises.
- R6: RAS stays low for exactly RAS_LOW_CYC cycles in each refresh. Between two refreshes RAS is high for at least PRECHARGE_CYC + CAS_SETUP_CYC cycles.
- R7: we_n_o is 1 whenever RAS falls.
- R8: After mem_ready_o rises, rfsh_req_o first goes high exactly INTERVAL_CYC cycles later, provided no grant is given. After that, one refresh becomes owed every INTERVAL_CYC cycles.
- R9: No refresh starts while rfsh_gnt_i is low and rfsh_urgent_o is low. With one refresh owed and the grant high, exactly one refresh is run and then rfsh_req_o falls.
- R10: If the grant is withheld for k interval ticks (k below 8) and then held high, exactly k refreshes are run back to back before rfsh_req_o falls.
- R11: rfsh_urgent_o rises when the eighth refresh becomes owed. A refresh then starts without a grant, and RAS falls two cycles after the urgent flag is seen. After that one refresh the flag drops and no further refresh runs without a grant.
- R12: A one-cycle restart pulse in idle makes mem_ready_o low in the next cycle. RAS falls two cycles after the pulse, with no pause. Exactly eight refreshes are run before mem_ready_o rises again.
- R13: rfsh_req_o is low whenever mem_ready_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Pulse that reruns the eight initialisation cycles without the pause |
| rfsh_gnt_i | input | 1 | Grant from the access controller: the block may drive the memory pins |
| rfsh_req_o | output | 1 | At least one refresh is owed and the block is idle and ready |
| rfsh_urgent_o | output | 1 | Eight or more refreshes are owed; refreshes start without a grant |
| mem_ready_o | output | 1 | Initialisation is complete and normal accesses are allowed |
| bus_own_o | output | 1 | The block is driving the strobes for a refresh in progress |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_hi_n_o | output | 1 | Upper-byte column strobe, active low |
| cas_lo_n_o | output | 1 | Lower-byte column strobe, active low |
| we_n_o | output | 1 | Write strobe, held high |

## Verification
A wrong phase counter shows at the pins at the very next strobe edge. Such a fault appears as a CAS setup or hold time that is one cycle off, or a RAS pulse or precharge gap of the wrong length, and it is detected at the first refresh after reset. A wrong owed count only becomes visible at the end of a postponement. The burst after the grant then runs one refresh too many or too few, or the urgent flag fires a whole interval early or late. A fault in the initialisation count shows when ready rises, which happens after a different number of RAS pulses than eight, both after reset and after a restart.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        PH_PAUSE = 3'd0,
        PH_IDLE  = 3'd1,
        PH_SETUP = 3'd2,
        PH_RASLO = 3'd3,
        PH_PRECH = 3'd4
    } rfsh_phase_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: ticks are separated by a full interval, never adjacent
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
    parameter int unsigned OWED_MAX   = 15,
    parameter int unsigned URGENT_LVL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic owed_nz,
    output logic urgent
);
    localparam int unsigned OW = $clog2(OWED_MAX + 1);
    localparam logic [OW-1:0] CMAX = OW'(OWED_MAX);
    localparam logic [OW-1:0] CURG = OW'(URGENT_LVL);

    logic [OW-1:0] cnt_d, cnt_q;

    assign owed_nz = (cnt_q != '0);
    assign urgent  = (cnt_q >= CURG);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: a completed refresh is only reported while one is owed
    p_dec_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr) |-> (cnt_q != '0));
    // R10: the count saturates instead of wrapping
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && cnt_q == CMAX) |=> (cnt_q == CMAX));
    // R10: a lone tick adds exactly one
    p_step_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/rfsh_cbr_engine.sv
module rfsh_cbr_engine
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC      = 20000,
    parameter int unsigned CAS_SETUP_CYC  = 1,
    parameter int unsigned CAS_HOLD_CYC   = 2,
    parameter int unsigned RAS_LOW_CYC    = 6,
    parameter int unsigned PRECHARGE_CYC  = 4,
    parameter int unsigned INIT_CYCLES    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic gnt,
    input  logic owed_nz,
    input  logic urgent,
    output logic req,
    output logic ready,
    output logic own_bus,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int unsigned LMAX = max2(max2(PAUSE_CYC, CAS_SETUP_CYC),
                                        max2(RAS_LOW_CYC, PRECHARGE_CYC));
    localparam int unsigned CW = $clog2(LMAX + 1);
    localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LD_PAUSE = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] LD_SETUP = CW'(CAS_SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_RASLO = CW'(RAS_LOW_CYC - 1);
    localparam logic [CW-1:0] LD_PRECH = CW'(PRECHARGE_CYC - 1);
    localparam logic [CW-1:0] HOLD_THR = CW'(RAS_LOW_CYC - 1 - CAS_HOLD_CYC);
    localparam logic [IW-1:0] INIT_LD  = IW'(INIT_CYCLES);

    typedef struct packed {
        rfsh_phase_e   ph;
        logic [CW-1:0] cnt;
        logic [IW-1:0] init_left;
        logic          ready;
        logic          norm;
        logic          pend;
        logic          ras_n;
        logic          cas_n;
    } eng_s;

    eng_s s_d, s_q;

    assign req     = (s_q.ph == PH_IDLE) && s_q.ready && owed_nz;
    assign ready   = s_q.ready;
    assign own_bus = (s_q.ph == PH_SETUP) || (s_q.ph == PH_RASLO) || (s_q.ph == PH_PRECH);
    assign done    = (s_q.ph == PH_PRECH) && (s_q.cnt == '0) && s_q.norm;
    assign ras_n   = s_q.ras_n;
    assign cas_n   = s_q.cas_n;

    always_comb begin
        s_d = s_q;
        if (restart && s_q.ph != PH_PAUSE) begin
            s_d.ready = 1'b0;
            s_d.pend  = 1'b1;
        end
        unique case (s_q.ph)
            PH_PAUSE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_SETUP;
                    s_d.cnt  = LD_SETUP;
                    s_d.norm = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_IDLE: begin
                if (s_d.pend) begin
                    s_d.pend      = 1'b0;
                    s_d.init_left = INIT_LD;
                    s_d.ph        = PH_SETUP;
                    s_d.cnt       = LD_SETUP;
                    s_d.norm      = 1'b0;
                end else if (s_q.ready && owed_nz && (gnt || urgent)) begin
                    s_d.ph   = PH_SETUP;
                    s_d.cnt  = LD_SETUP;
                    s_d.norm = 1'b1;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_RASLO;
                    s_d.cnt = LD_RASLO;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RASLO: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_PRECH;
                    s_d.cnt = LD_PRECH;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_PRECH: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_d.pend) begin
                    s_d.pend      = 1'b0;
                    s_d.init_left = INIT_LD;
                    s_d.ph        = PH_SETUP;
                    s_d.cnt       = LD_SETUP;
                    s_d.norm      = 1'b0;
                end else if (!s_q.norm) begin
                    if (s_q.init_left == IW'(1)) begin
                        s_d.init_left = '0;
                        s_d.ready     = 1'b1;
                        s_d.ph        = PH_IDLE;
                    end else begin
                        s_d.init_left = s_q.init_left - 1'b1;
                        s_d.ph        = PH_SETUP;
                        s_d.cnt       = LD_SETUP;
                    end
                end else begin
                    s_d.ph = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        s_d.ras_n = (s_d.ph != PH_RASLO);
        s_d.cas_n = !((s_d.ph == PH_SETUP) ||
                      ((s_d.ph == PH_RASLO) && (s_d.cnt > HOLD_THR)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph        <= PH_PAUSE;
            s_q.cnt       <= LD_PAUSE;
            s_q.init_left <= INIT_LD;
            s_q.ready     <= 1'b0;
            s_q.norm      <= 1'b0;
            s_q.pend      <= 1'b0;
            s_q.ras_n     <= 1'b1;
            s_q.cas_n     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: the row strobe only falls while the column strobe was already low
    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == 1'b0 && cas_n == 1'b0));
    // R5: the column strobe is released before the row strobe rises
    p_cas_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);
    // R9: no start from idle without a grant or urgency
    p_wait_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && !gnt && !urgent && !restart && !s_q.pend) |=> (s_q.ph == PH_IDLE));
    // R11: urgency starts a refresh from idle
    p_urgent_forces_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && s_q.ready && urgent) |=> (s_q.ph == PH_SETUP));
    // R13: no request while not ready
    p_no_req_unready_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !req);
    // R3: ready rises only at the end of a precharge
    p_ready_after_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(s_q.ph) == PH_PRECH));

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer #(
    parameter int unsigned PAUSE_CYC      = 20000,
    parameter int unsigned INTERVAL_CYC   = 1560,
    parameter int unsigned CAS_SETUP_CYC  = 1,
    parameter int unsigned CAS_HOLD_CYC   = 2,
    parameter int unsigned RAS_LOW_CYC    = 6,
    parameter int unsigned PRECHARGE_CYC  = 4,
    parameter int unsigned INIT_CYCLES    = 8,
    parameter int unsigned OWED_MAX       = 15,
    parameter int unsigned URGENT_LVL     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic rfsh_gnt_i,
    output logic rfsh_req_o,
    output logic rfsh_urgent_o,
    output logic mem_ready_o,
    output logic bus_own_o,
    output logic ras_n_o,
    output logic cas_hi_n_o,
    output logic cas_lo_n_o,
    output logic we_n_o
);
    localparam int unsigned LANES = 2;

    logic tick, owed_nz, urgent, ready, done, cas_n;
    logic [LANES-1:0] cas_lane_n;

    rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ready),
        .tick (tick)
    );

    rfsh_owed_counter #(.OWED_MAX(OWED_MAX), .URGENT_LVL(URGENT_LVL)) u_owed (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!ready),
        .inc    (tick),
        .dec    (done),
        .owed_nz(owed_nz),
        .urgent (urgent)
    );

    rfsh_cbr_engine #(
        .PAUSE_CYC    (PAUSE_CYC),
        .CAS_SETUP_CYC(CAS_SETUP_CYC),
        .CAS_HOLD_CYC (CAS_HOLD_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .PRECHARGE_CYC(PRECHARGE_CYC),
        .INIT_CYCLES  (INIT_CYCLES)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart_i),
        .gnt    (rfsh_gnt_i),
        .owed_nz(owed_nz),
        .urgent (urgent),
        .req    (rfsh_req_o),
        .ready  (ready),
        .own_bus(bus_own_o),
        .done   (done),
        .ras_n  (ras_n_o),
        .cas_n  (cas_n)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cas_lane_n[g] = cas_n;
    end

    assign cas_lo_n_o    = cas_lane_n[0];
    assign cas_hi_n_o    = cas_lane_n[1];
    assign we_n_o        = 1'b1;
    assign mem_ready_o   = ready;
    assign rfsh_urgent_o = urgent && ready;

endmodule

// File: tb/sim_dram_refresh_sequencer.sv
module sim_dram_refresh_sequencer;
    localparam int unsigned PAUSE    = 20;
    localparam int unsigned INTERVAL = 150;
    localparam int unsigned SETUP    = 1;
    localparam int unsigned HOLD     = 2;
    localparam int unsigned RLOW     = 5;
    localparam int unsigned PRE      = 4;
    localparam int unsigned N_VEC    = 5;
    localparam int unsigned VEC_MISS  [N_VEC] = '{2, 4, 1, 7, 3};
    localparam int unsigned VEC_BURST [N_VEC] = '{2, 4, 1, 7, 3};

    logic clk = 1'b0;
    logic rst_n, restart, gnt;
    logic req, urgent, ready, own, ras_n, cas_hi_n, cas_lo_n, we_n;

    int checks = 0;
    int fails  = 0;
    int fall_cnt = 0;
    int since = 0;
    int gap = 1000;
    logic ras_p = 1'b1, cas_p = 1'b1;

    always #5 clk = ~clk;

    dram_refresh_sequencer #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .CAS_SETUP_CYC(SETUP),
        .CAS_HOLD_CYC(HOLD), .RAS_LOW_CYC(RLOW), .PRECHARGE_CYC(PRE),
        .INIT_CYCLES(8), .OWED_MAX(15), .URGENT_LVL(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .rfsh_gnt_i(gnt),
        .rfsh_req_o(req), .rfsh_urgent_o(urgent), .mem_ready_o(ready),
        .bus_own_o(own), .ras_n_o(ras_n), .cas_hi_n_o(cas_hi_n),
        .cas_lo_n_o(cas_lo_n), .we_n_o(we_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pin-level monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras_p && !ras_n) begin
                fall_cnt++;
                chk(!cas_p && !cas_hi_n && !cas_lo_n, "R4 cas low before ras", int'(cas_hi_n), 0);
                chk(we_n == 1'b1, "R7 we high", int'(we_n), 1);
                if (gap < 1000) chk(gap >= int'(PRE + SETUP), "R6 precharge gap", gap, PRE + SETUP);
                since = 1;
            end else if (!ras_p && ras_n) begin
                chk(since == int'(RLOW), "R6 ras low width", since, RLOW);
                chk(cas_hi_n && cas_lo_n, "R5 cas high at ras rise", int'(cas_hi_n), 1);
                gap = 1;
            end else if (!ras_n) begin
                since++;
            end else if (gap < 1000) begin
                gap++;
            end
            if (!ras_n && !ras_p && cas_p == 1'b0 && cas_hi_n)
                chk(since == int'(HOLD + 1), "R5 cas hold", since - 1, HOLD);
            ras_p = ras_n;
            cas_p = cas_hi_n;
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic serve_burst(output int n);
        int f0;
        f0 = fall_cnt;
        gnt = 1'b1;
        do @(negedge clk); while (own || req);
        gnt = 1'b0;
        n = fall_cnt - f0;
    endtask

    initial begin : watchdog
        wait_neg(150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int i, n, f0;
        rst_n = 1'b0; restart = 1'b0; gnt = 1'b0;
        wait_neg(3);
        chk(ras_n && cas_hi_n && cas_lo_n && we_n, "R1 strobes idle", int'(ras_n), 1);
        chk(!ready && !req && !own, "R1 flags low", int'(ready), 0);
        rst_n = 1'b1;

        // R2: pause then first refresh
        i = 0;
        do begin
            @(negedge clk); i++;
            if (i < int'(PAUSE)) chk(cas_hi_n && cas_lo_n, "R2 cas high in pause", int'(cas_hi_n), 1);
        end while (ras_n && i < 200);
        chk(i == int'(PAUSE + SETUP), "R2 first ras fall", i, PAUSE + SETUP);

        // R3: eight cycles then ready
        i = 0;
        while (!ready && i < 500) begin @(negedge clk); i++; end
        chk(fall_cnt == 8, "R3 init cycles", fall_cnt, 8);

        // R8: first request after one interval
        for (int k = 1; k <= int'(INTERVAL); k++) begin
            @(negedge clk);
            if (k == int'(INTERVAL) - 1) chk(!req, "R8 no early req", int'(req), 0);
            if (k == int'(INTERVAL))     chk(req,  "R8 req on time",  int'(req), 1);
        end

        // R9: no refresh without grant, one with grant
        f0 = fall_cnt;
        wait_neg(30);
        chk(fall_cnt == f0 && req, "R9 held off without grant", fall_cnt - f0, 0);
        serve_burst(n);
        chk(n == 1, "R9 single refresh", n, 1);

        // R10: vector table of postponements
        for (int v = 0; v < int'(N_VEC); v++) begin
            do @(negedge clk); while (!req);
            wait_neg(int'((VEC_MISS[v] - 1) * INTERVAL) + 2);
            chk(!urgent, "R11 below threshold", int'(urgent), 0);
            serve_burst(n);
            chk(n == int'(VEC_BURST[v]), "R10 catch-up burst", n, VEC_BURST[v]);
        end

        // R11: urgent forcing
        do @(negedge clk); while (!req);
        i = 0;
        while (!urgent && i < 3000) begin @(negedge clk); i++; end
        chk(i == int'(7 * INTERVAL), "R11 urgent timing", i, 7 * INTERVAL);
        i = 0;
        while (ras_n && i < 20) begin @(negedge clk); i++; end
        chk(i == 2, "R11 forced start", i, 2);
        while (own) @(negedge clk);
        chk(!urgent, "R11 urgent drops", int'(urgent), 0);
        f0 = fall_cnt;
        wait_neg(30);
        chk(fall_cnt == f0, "R11 no more without grant", fall_cnt - f0, 0);
        serve_burst(n);
        chk(n == 7, "R10 remaining owed", n, 7);

        // R12: restart
        f0 = fall_cnt;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk(!ready, "R12 ready drops", int'(ready), 0);
        i = 1;
        while (ras_n && i < 50) begin @(negedge clk); i++; end
        chk(i == int'(SETUP + 1), "R12 no pause", i, SETUP + 1);
        i = 0;
        while (!ready && i < 500) begin
            if (req) chk(1'b0, "R13 req while not ready", 1, 0);
            @(negedge clk); i++;
        end
        chk(!req, "R13 req low during init", int'(req), 0);
        chk(fall_cnt - f0 == 8, "R12 eight cycles", fall_cnt - f0, 8);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule